// File: doc/BRIEF.md
# USB Full/Low-Speed Line Receiver

This block sits behind a USB transceiver that supplies synchronised single-ended copies of D+ and D-. Because it looks at both lines instead of only the differential comparator, it can tell apart the four line states J, K, SE0 and SE1. The polarity of J and K is set by a speed-select input. On every bit-time strobe it decodes NRZI, removes the zero that the transmitter stuffs after a run of ones, flags a stuffing violation and recognises end-of-packet.

Alongside the bit decoder, a timer counts system-clock cycles spent in SE0. Once that run exceeds a parameterised limit, which defaults to 10 ms at 125 MHz, the timer reports a bus reset as a single pulse. Downstream packet logic uses the decoded bit stream, its valid strobe and the end-of-packet pulse. Device control logic uses the reset pulse.

Top module: `usb_line_rx`

## Requirements
- R1: `line_state` shows the sample of {dp,dm} taken at the previous clock edge, encoded as 0 = SE0 (both low), 1 = J, 2 = K, 3 = SE1 (both high). At full speed (`low_speed`=0), J is dp=1/dm=0. At low speed, J is dp=0/dm=1. K is always the opposite of J.
- R2: On a J or K sample taken with `bit_en` high, the block emits one decoded bit one cycle later with `bit_valid` high. The bit is 0 when the state differs from the previous J/K bit time and 1 when it is the same. After reset the previous state is J.
- R3: After STUFF_LEN (default 6) consecutive decoded 1 bits, the next bit time is treated as a stuffed 0 and is dropped: no `bit_valid`, and the ones count restarts.
- R4: If that stuffed bit time decodes as 1, `stuff_err` pulses for one cycle, no bit is emitted and the ones count restarts.
- R5: An SE1 sample emits no bit and leaves the decoder state unchanged; decoding continues as if the SE1 bit time had not occurred.
- R6: A J sample that follows at least two consecutive SE0 bit times pulses `eop` for one cycle and emits no bit. The previous state becomes J and the ones count is cleared.
- R7: When SE0 is present on more than RESET_CYCLES consecutive clock samples, `bus_reset` pulses once, one cycle after sample RESET_CYCLES+1. It does not pulse again while SE0 continues.
- R8: Any non-SE0 clock sample clears the SE0 duration count, so shorter SE0 runs separated by other states never raise `bus_reset`.
- R9: While in reset and just after it, `line_state` reads J, and `bit_valid`, `stuff_err`, `eop` and `bus_reset` are low.
- R10: A single SE0 bit time that is followed by J or K emits no bit and does not disturb NRZI decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_speed | input | 1 | 1 selects low-speed J/K polarity |
| dp | input | 1 | Synchronised D+ sample |
| dm | input | 1 | Synchronised D- sample |
| bit_en | input | 1 | Strobe marking the current sample as a bit time |
| line_state | output | 2 | Registered line state (0 SE0, 1 J, 2 K, 3 SE1) |
| bit_out | output | 1 | Decoded data bit |
| bit_valid | output | 1 | `bit_out` holds a new decoded bit |
| stuff_err | output | 1 | One-cycle pulse on a bit-stuffing violation |
| eop | output | 1 | One-cycle pulse on end-of-packet |
| bus_reset | output | 1 | One-cycle pulse when an SE0 run exceeds the reset limit |

## Verification
The assertions check several properties on every cycle. `bit_valid` never coincides with `stuff_err` or `eop`. The ones counter never passes the stuffing limit. A bit appears only after a bit-time strobe. `bus_reset` is a single-cycle pulse that appears only while the line is in SE0. Other behaviours are shown only by the bench scenarios: that the decoded stream matches the data a transmitter model encoded with NRZI and stuffing, at both speeds; that SE1 and a lone SE0 leave decoding intact; that EOP resynchronises to J; and that the reset timer fires exactly at its threshold but not for broken SE0 runs.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'd0,
        LS_J   = 2'd1,
        LS_K   = 2'd2,
        LS_SE1 = 2'd3
    } line_t;
endpackage

// File: rtl/usb_line_classify.sv
module usb_line_classify
    import usb_rx_pkg::*;
(
    input  logic  dp,
    input  logic  dm,
    input  logic  low_speed,
    output line_t state
);
    // R1: polarity of the differential states flips with the speed select
    always_comb begin
        case ({dp, dm})
            2'b00:   state = LS_SE0;
            2'b11:   state = LS_SE1;
            2'b10:   state = low_speed ? LS_K : LS_J;
            default: state = low_speed ? LS_J : LS_K;
        endcase
    end
endmodule

// File: rtl/usb_nrzi_destuff.sv
module usb_nrzi_destuff
    import usb_rx_pkg::*;
#(
    parameter int STUFF_LEN = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  line_t state,
    output logic  bit_out,
    output logic  bit_valid,
    output logic  stuff_err,
    output logic  eop
);
    localparam int ONES_W = $clog2(STUFF_LEN + 1);

    typedef struct packed {
        logic              prev_k;
        logic [ONES_W-1:0] ones;
        logic [1:0]        se0_run;
        logic              dbit;
        logic              valid;
        logic              err;
        logic              eop;
    } dec_t;

    dec_t dec_d, dec_q;
    logic cur_k;
    logic dbit_now;

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = 1'b0;
        dec_d.err   = 1'b0;
        dec_d.eop   = 1'b0;
        cur_k       = (state == LS_K);
        dbit_now    = (cur_k == dec_q.prev_k);
        if (bit_en) begin
            case (state)
                LS_SE0: begin
                    if (dec_q.se0_run != 2'd2) dec_d.se0_run = dec_q.se0_run + 2'd1;
                end
                LS_SE1: ; // R5: illegal state, decoder holds
                default: begin
                    dec_d.se0_run = 2'd0;
                    if (dec_q.se0_run == 2'd2 && !cur_k) begin
                        dec_d.eop    = 1'b1;  // R6
                        dec_d.prev_k = 1'b0;
                        dec_d.ones   = '0;
                    end else begin
                        dec_d.prev_k = cur_k;
                        if (dec_q.ones == ONES_W'(STUFF_LEN)) begin
                            dec_d.ones = '0;       // R3: drop stuffed bit
                            dec_d.err  = dbit_now; // R4
                        end else begin
                            dec_d.valid = 1'b1;
                            dec_d.dbit  = dbit_now;
                            dec_d.ones  = dbit_now ? dec_q.ones + ONES_W'(1) : '0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign bit_out   = dec_q.dbit;
    assign bit_valid = dec_q.valid;
    assign stuff_err = dec_q.err;
    assign eop       = dec_q.eop;

    p_valid_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && stuff_err));
    p_ones_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.ones <= ONES_W'(STUFF_LEN));
    p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(bit_en));
    p_eop_no_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (!bit_valid && $past(state == LS_J)));
endmodule

// File: rtl/usb_reset_timer.sv
module usb_reset_timer #(
    parameter int RESET_CYCLES = 1_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se0_now,
    output logic bus_reset
);
    localparam int CNT_W = $clog2(RESET_CYCLES + 2);
    localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(RESET_CYCLES);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(RESET_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.pulse = 1'b0;
        if (!se0_now) begin
            tmr_d.cnt = '0;  // R8
        end else if (tmr_q.cnt != CNT_SAT) begin
            tmr_d.cnt   = tmr_q.cnt + CNT_W'(1);
            tmr_d.pulse = (tmr_q.cnt == CNT_TRIP);  // R7
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign bus_reset = tmr_q.pulse;

    p_reset_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);
    p_reset_needs_se0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> $past(se0_now));
endmodule

// File: rtl/usb_line_rx.sv
module usb_line_rx
    import usb_rx_pkg::*;
#(
    parameter int RESET_CYCLES = 1_250_000,
    parameter int STUFF_LEN    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_speed,
    input  logic       dp,
    input  logic       dm,
    input  logic       bit_en,
    output logic [1:0] line_state,
    output logic       bit_out,
    output logic       bit_valid,
    output logic       stuff_err,
    output logic       eop,
    output logic       bus_reset
);
    line_t state_now;
    line_t ls_d, ls_q;

    usb_line_classify u_class (
        .dp        (dp),
        .dm        (dm),
        .low_speed (low_speed),
        .state     (state_now)
    );

    always_comb ls_d = state_now;

    always_ff @(posedge clk) begin
        if (!rst_n) ls_q <= LS_J;  // R9
        else        ls_q <= ls_d;
    end

    assign line_state = ls_q;

    usb_nrzi_destuff #(.STUFF_LEN(STUFF_LEN)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .state     (state_now),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .stuff_err (stuff_err),
        .eop       (eop)
    );

    usb_reset_timer #(.RESET_CYCLES(RESET_CYCLES)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .se0_now   (state_now == LS_SE0),
        .bus_reset (bus_reset)
    );

    p_reset_in_se0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> (line_state == LS_SE0));
    p_eop_on_j_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (line_state == LS_J));
    p_valid_not_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && eop));
endmodule

// File: tb/usb_line_rx_tb.sv
module usb_line_rx_tb;
    localparam int RST_LIM = 40;

    logic clk = 1'b0, rst_n = 1'b0, low_speed = 1'b0;
    logic dp = 1'b1, dm = 1'b0, bit_en = 1'b0;
    logic [1:0] line_state;
    logic bit_out, bit_valid, stuff_err, eop, bus_reset;

    int checks = 0, errors = 0;
    int vcnt = 0, ecnt = 0, eopcnt = 0, rcnt = 0;
    bit exp_q[$];
    logic enc_k = 1'b0;
    int   enc_ones = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    usb_line_rx #(.RESET_CYCLES(RST_LIM), .STUFF_LEN(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .dp(dp), .dm(dm),
        .bit_en(bit_en), .line_state(line_state), .bit_out(bit_out),
        .bit_valid(bit_valid), .stuff_err(stuff_err), .eop(eop),
        .bus_reset(bus_reset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                vcnt++;
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected bit", int'(bit_out), -1);
                else begin
                    automatic bit e = exp_q.pop_front();
                    chk(bit_out == e, "R2/R3 decoded bit", int'(bit_out), int'(e));
                end
            end
            if (stuff_err) ecnt++;
            if (eop)       eopcnt++;
            if (bus_reset) rcnt++;
        end
    end

    // level codes: 0 SE0, 1 J, 2 K, 3 SE1
    task automatic send_level(input int s);
        @(negedge clk);
        case (s)
            0: begin dp = 1'b0; dm = 1'b0; end
            3: begin dp = 1'b1; dm = 1'b1; end
            1: begin dp = ~low_speed; dm = low_speed; end
            default: begin dp = low_speed; dm = ~low_speed; end
        endcase
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        if (!b) enc_k = ~enc_k;
        exp_q.push_back(b);
        send_level(enc_k ? 2 : 1);
        enc_ones = b ? enc_ones + 1 : 0;
        if (enc_ones == 6) begin
            enc_k = ~enc_k;
            send_level(enc_k ? 2 : 1);
            enc_ones = 0;
        end
    endtask

    task automatic send_word(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i]);
    endtask

    task automatic send_eop();
        automatic int e0 = eopcnt;
        send_level(0);
        send_level(0);
        send_level(1);
        enc_k = 1'b0;
        enc_ones = 0;
        chk(eopcnt == e0 + 1, "R6 eop pulse", eopcnt - e0, 1);
    endtask

    task automatic raw_state(input logic p, input logic m, input int exp, input string req);
        @(negedge clk);
        dp = p; dm = m;
        @(negedge clk);
        chk(int'(line_state) == exp, req, int'(line_state), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(line_state == 2'd1, "R9 line_state reset", int'(line_state), 1);
        chk(!bit_valid && !stuff_err && !eop && !bus_reset, "R9 outputs low",
            int'({bit_valid, stuff_err, eop, bus_reset}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bit_valid && !bus_reset, "R9 after release", int'({bit_valid, bus_reset}), 0);

        // R1 classification at both speeds
        low_speed = 1'b0;
        raw_state(1'b1, 1'b0, 1, "R1 full J");
        raw_state(1'b0, 1'b1, 2, "R1 full K");
        raw_state(1'b0, 1'b0, 0, "R1 SE0");
        raw_state(1'b1, 1'b1, 3, "R1 SE1");
        low_speed = 1'b1;
        raw_state(1'b0, 1'b1, 1, "R1 low J");
        raw_state(1'b1, 1'b0, 2, "R1 low K");
        low_speed = 1'b0;
        raw_state(1'b1, 1'b0, 1, "R1 back to J");

        // R2 full speed data
        send_word(32'hA5C3_0F96, 32);
        send_eop();
        // R3 long run of ones needing several stuffed zeros
        begin
            automatic int v0 = vcnt;
            send_word(32'h00FF_FFFF, 28);
            chk(vcnt == v0 + 28, "R3 stuffed bits dropped", vcnt - v0, 28);
        end
        send_eop();

        // R5 SE1 in the middle of a packet
        send_word(32'h0000_003B, 7);
        begin
            automatic int v0 = vcnt;
            send_level(3);
            chk(vcnt == v0, "R5 SE1 emits nothing", vcnt - v0, 0);
            chk(line_state == 2'd3, "R5 SE1 reported", int'(line_state), 3);
        end
        send_word(32'h0000_00C4, 8);

        // R10 lone SE0 bit time
        begin
            automatic int v0 = vcnt;
            automatic int e0 = eopcnt;
            send_level(0);
            chk(vcnt == v0, "R10 SE0 emits nothing", vcnt - v0, 0);
            send_word(32'h0000_0035, 6);
            chk(eopcnt == e0, "R10 no eop", eopcnt - e0, 0);
        end
        send_eop();

        // R6 resync: first bit after EOP relative to J, ones count cleared
        send_word(32'h0000_003F, 8);
        send_eop();

        // R4 stuffing violation: seven J bit times after EOP
        begin
            automatic int e0 = ecnt;
            automatic int v0 = vcnt;
            for (int i = 0; i < 6; i++) begin
                exp_q.push_back(1'b1);
                send_level(1);
            end
            send_level(1);
            chk(ecnt == e0 + 1, "R4 stuff error pulse", ecnt - e0, 1);
            chk(vcnt == v0 + 6, "R4 no bit on error", vcnt - v0, 6);
        end
        send_eop();

        // R2 low speed data
        low_speed = 1'b1;
        send_word(32'h5A3C_E187, 32);
        send_eop();
        low_speed = 1'b0;
        send_eop();
        chk(exp_q.size() == 0, "R2 all bits seen", exp_q.size(), 0);

        // R7 reset timer threshold
        begin
            automatic int r0 = rcnt;
            @(negedge clk);
            dp = 1'b0; dm = 1'b0;
            repeat (RST_LIM) @(negedge clk);
            chk(!bus_reset, "R7 not yet at limit", int'(bus_reset), 0);
            @(negedge clk);
            chk(bus_reset, "R7 pulse after limit", int'(bus_reset), 1);
            repeat (20) @(negedge clk);
            chk(rcnt == r0 + 1, "R7 single pulse", rcnt - r0, 1);
            dp = 1'b1; dm = 1'b0;
            repeat (2) @(negedge clk);
        end
        // R8 broken SE0 runs
        begin
            automatic int r0 = rcnt;
            dp = 1'b0; dm = 1'b0;
            repeat (RST_LIM - 1) @(negedge clk);
            dp = 1'b0; dm = 1'b1;
            @(negedge clk);
            dp = 1'b0; dm = 0;
            repeat (RST_LIM - 1) @(negedge clk);
            dp = 1'b1; dm = 1'b0;
            repeat (3) @(negedge clk);
            chk(rcnt == r0, "R8 timer cleared", rcnt - r0, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule